// File: doc/BRIEF.md
# G.711 Audio Compander

This block sits in the digital core of an audio codec between the converter sample paths and the serial audio port. On the transmit (capture) path it takes a 16-bit two's-complement linear sample and, when companding is selected, compresses it into an 8-bit logarithmic code using either the mu-law or the A-law curve. On the receive (playback) path it takes a serial data word, picks out the 8-bit code and expands it back to a 16-bit linear sample. Each code is made of a sign bit, a 3-bit segment number and a 4-bit step within the segment. The linear range is cut into eight segments, so quiet signals get finer steps than loud ones.

Each path has its own 2-bit mode field, and each field is sampled together with the data it governs. The two line-code inversion rules are handled inside the block. A compressed code always occupies the top eight bits of the 16-bit word. A plain flag tells the serial port to use 8-bit words whenever either path is companding.

Both data paths are valid/ready streams with one register stage each. An input is accepted on a rising clock edge when `*_in_valid` and `*_in_ready` are both high. `*_in_ready` is high when the stage is empty or when its output is being taken in the same cycle. A presented output holds its value until `*_out_ready` takes it. The two paths never stall each other.

Top module: `g711_compander`

## Requirements
- R1: Mode 00 (off) and mode 01 (reserved) pass the word through unchanged on both paths: `tx_out_data` equals the accepted `tx_in_data`, and `rx_out_data` equals the accepted `rx_in_data`.
- R2: mu-law compression (mode 10) works as follows. Take x = sample arithmetically shifted right by 2 (14 bits). Take the magnitude of x, clip it to 8159 and add 33 to get b. The segment s is the smallest value in 0..7 with b < 64<<s, and the step is bits [s+4:s+1] of b. If b >= 8192, the segment is 7 and the step is 15. The raw code is {negative, s, step}, and all 8 bits are inverted. So 0 gives 8'hFF, 32767 gives 8'h80 and -32768 gives 8'h00.
- R3: A-law compression (mode 11) works as follows. Take x = sample arithmetically shifted right by 3. Take m = x when x is non-negative, otherwise m = -x-1. The segment s is the smallest value with m < 32<<s. The step is bits [4:1] of m when s < 2, otherwise bits [s+3:s]. The raw code is {non-negative, s, step} XOR 8'h55 (every even bit inverted). So 0 gives 8'hD5, 32767 gives 8'hAA and -32768 gives 8'h2A.
- R4: A compressed transmit word carries the code in bits [15:8] and zeros in bits [7:0].
- R5: mu-law expansion uses bits [15:8] of the receive word and ignores bits [7:0]. Let u be the code inverted, and t = (u[3:0]*8 + 132) << u[6:4]. The output is 132-t when u[7] is set, otherwise t-132. Code 8'hFF gives 0 and code 8'h80 gives 32124.
- R6: A-law expansion uses bits [15:8] of the receive word and ignores bits [7:0]. Let a be the code XOR 8'h55, and t = a[3:0]*16 + 8 for segment a[6:4] = 0. For other segments, t = (a[3:0]*16 + 264) << (a[6:4]-1). The output is t when a[7] is set, otherwise -t. Code 8'hD5 gives 8 and code 8'hAA gives 32256.
- R7: `word8_mode` is high exactly when bit 1 of `tx_mode` or bit 1 of `rx_mode` is high.
- R8: During and after reset both output valids are low and both input readies are high. A word accepted on an edge appears on the output, valid, directly after that same edge (one-cycle latency).
- R9: An input ready is high only when its output is empty or is being taken. A stalled output keeps its data unchanged, and no accepted word is lost or duplicated.
- R10: The paths are independent. Words in both directions may be accepted in the same cycle under different modes, and a stall on one path does not slow or alter the other.
- R11: The mode used for a word is the one present when that word is accepted. A later mode change does not alter a word already held at the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_mode | input | 2 | Transmit mode: 00 off, 01 reserved, 10 mu-law, 11 A-law |
| rx_mode | input | 2 | Receive mode, same encoding |
| word8_mode | output | 1 | Request for 8-bit serial words |
| tx_in_valid | input | 1 | Linear sample offered |
| tx_in_ready | output | 1 | Transmit stage can accept |
| tx_in_data | input | 16 | Linear sample, two's complement |
| tx_out_valid | output | 1 | Transmit word present |
| tx_out_ready | input | 1 | Serial side takes transmit word |
| tx_out_data | output | 16 | Code in [15:8] or the linear sample |
| rx_in_valid | input | 1 | Receive word offered |
| rx_in_ready | output | 1 | Receive stage can accept |
| rx_in_data | input | 16 | Received word, code in [15:8] |
| rx_out_valid | output | 1 | Linear sample present |
| rx_out_ready | input | 1 | Playback side takes sample |
| rx_out_data | output | 16 | Expanded or passed-through sample |

## Verification
Compression of a capture sample and expansion of a playback code can happen in the same clock cycle, each under its own law. The bench offers words on both paths in one cycle with mixed modes and checks both results against separately computed values. It then stalls only the transmit output while the receive path keeps streaming, and checks that the receive results arrive every cycle. It also checks that the held transmit code, and the code taken once the stall is released, are exactly the words that were accepted.

// File: rtl/g711_pkg.sv
package g711_pkg;
  typedef enum logic [1:0] {
    CMP_OFF  = 2'b00,
    CMP_RSVD = 2'b01,
    CMP_MU   = 2'b10,
    CMP_A    = 2'b11
  } comp_mode_e;

  localparam int CODE_W = 8;
  localparam int SEGS   = 8;
  localparam logic [CODE_W-1:0] ALAW_MASK = 8'h55;
endpackage

// File: rtl/g711_seg_find.sv
module g711_seg_find #(
  parameter int SEGS_P = 8,
  localparam int CNT_W = $clog2(SEGS_P + 1)
) (
  input  logic [SEGS_P-1:0] hi,
  output logic [CNT_W-1:0]  count
);
  logic [SEGS_P-1:0] above;

  for (genvar i = 0; i < SEGS_P; i++) begin : g_thr
    assign above[i] = |hi[SEGS_P-1:i];
  end

  always_comb begin
    count = '0;
    for (int i = 0; i < SEGS_P; i++) begin
      count = count + CNT_W'(above[i]);
    end
  end
endmodule

// File: rtl/g711_encoder.sv
module g711_encoder
  import g711_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] sample,
  input  comp_mode_e        mode,
  output logic [DATA_W-1:0] word
);
  localparam int MU_W  = 14;
  localparam int A_W   = 13;
  localparam int LOW_W = DATA_W - CODE_W;
  localparam int CNT_W = $clog2(SEGS + 1);
  localparam logic [MU_W-1:0] MU_CLIP = MU_W'(8159);
  localparam logic [MU_W-1:0] MU_BIAS = MU_W'(33);

  logic neg;
  assign neg = sample[DATA_W-1];

  logic signed [MU_W-1:0] mu_x;
  logic [MU_W-1:0] mu_mag, mu_clip, mu_biased;
  logic [CNT_W-1:0] mu_cnt, mu_idx;
  logic [CODE_W-1:0] mu_raw, mu_code;

  assign mu_x      = sample[DATA_W-1 -: MU_W];
  assign mu_mag    = neg ? MU_W'(-mu_x) : mu_x;
  assign mu_clip   = (mu_mag > MU_CLIP) ? MU_CLIP : mu_mag;
  assign mu_biased = mu_clip + MU_BIAS;

  g711_seg_find #(.SEGS_P(SEGS)) u_mu_seg (
    .hi    (mu_biased[MU_W-1 -: SEGS]),
    .count (mu_cnt)
  );

  always_comb begin
    mu_idx = mu_cnt + CNT_W'(1);
    if (mu_cnt == CNT_W'(SEGS)) begin
      mu_raw = {neg, 3'd7, 4'hF};
    end else begin
      mu_raw = {neg, mu_cnt[2:0], mu_biased[mu_idx +: 4]};
    end
    mu_code = ~mu_raw;
  end

  logic [A_W-1:0] a_x, a_mag;
  logic [CNT_W-1:0] a_cnt;
  logic [3:0] a_step;
  logic [CODE_W-1:0] a_code;

  assign a_x   = sample[DATA_W-1 -: A_W];
  assign a_mag = neg ? ~a_x : a_x;

  g711_seg_find #(.SEGS_P(SEGS)) u_a_seg (
    .hi    (a_mag[A_W-1 -: SEGS]),
    .count (a_cnt)
  );

  always_comb begin
    if (a_cnt < CNT_W'(2)) a_step = a_mag[1 +: 4];
    else                   a_step = a_mag[a_cnt +: 4];
    a_code = {~neg, a_cnt[2:0], a_step} ^ ALAW_MASK;
  end

  always_comb begin
    unique case (mode)
      CMP_MU:  word = {mu_code, LOW_W'(0)};
      CMP_A:   word = {a_code, LOW_W'(0)};
      default: word = sample;
    endcase
  end
endmodule

// File: rtl/g711_decoder.sv
module g711_decoder
  import g711_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] word,
  input  comp_mode_e        mode,
  output logic [DATA_W-1:0] sample
);
  localparam int LIN_W = 16;

  logic [CODE_W-1:0] code, mu_u, a_v;
  logic [LIN_W-1:0] mu_t, mu_lin, a_base, a_t, a_lin;

  assign code = word[DATA_W-1 -: CODE_W];

  always_comb begin
    mu_u   = ~code;
    mu_t   = (LIN_W'({mu_u[3:0], 3'b000}) + LIN_W'(132)) << mu_u[6:4];
    mu_lin = mu_u[7] ? (LIN_W'(132) - mu_t) : (mu_t - LIN_W'(132));
  end

  always_comb begin
    a_v    = code ^ ALAW_MASK;
    a_base = LIN_W'({a_v[3:0], 4'b0000});
    if (a_v[6:4] == 3'd0) a_t = a_base + LIN_W'(8);
    else                  a_t = (a_base + LIN_W'(264)) << (a_v[6:4] - 3'd1);
    a_lin  = a_v[7] ? a_t : (LIN_W'(0) - a_t);
  end

  always_comb begin
    unique case (mode)
      CMP_MU:  sample = DATA_W'($signed(mu_lin));
      CMP_A:   sample = DATA_W'($signed(a_lin));
      default: sample = word;
    endcase
  end
endmodule

// File: rtl/g711_pipe_reg.sv
module g711_pipe_reg #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end

  // R9: a stalled word stays put
  a_r9_hold_stall: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  // R8: an accepted word shows up directly after the edge
  a_r8_accept_next: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid && out_data == $past(in_data));
endmodule

// File: rtl/g711_compander.sv
module g711_compander
  import g711_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        tx_mode,
  input  logic [1:0]        rx_mode,
  output logic              word8_mode,
  input  logic              tx_in_valid,
  output logic              tx_in_ready,
  input  logic [DATA_W-1:0] tx_in_data,
  output logic              tx_out_valid,
  input  logic              tx_out_ready,
  output logic [DATA_W-1:0] tx_out_data,
  input  logic              rx_in_valid,
  output logic              rx_in_ready,
  input  logic [DATA_W-1:0] rx_in_data,
  output logic              rx_out_valid,
  input  logic              rx_out_ready,
  output logic [DATA_W-1:0] rx_out_data
);
  localparam int LOW_W = DATA_W - CODE_W;
  localparam int PAY_W = DATA_W + 2;

  assign word8_mode = tx_mode[1] | rx_mode[1];

  logic [DATA_W-1:0] tx_word, rx_lin;
  logic [1:0] tx_tag, rx_tag;

  g711_encoder #(.DATA_W(DATA_W)) u_enc (
    .sample (tx_in_data),
    .mode   (comp_mode_e'(tx_mode)),
    .word   (tx_word)
  );

  g711_decoder #(.DATA_W(DATA_W)) u_dec (
    .word   (rx_in_data),
    .mode   (comp_mode_e'(rx_mode)),
    .sample (rx_lin)
  );

  g711_pipe_reg #(.W(PAY_W)) u_tx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (tx_in_valid),
    .in_ready  (tx_in_ready),
    .in_data   ({tx_mode, tx_word}),
    .out_valid (tx_out_valid),
    .out_ready (tx_out_ready),
    .out_data  ({tx_tag, tx_out_data})
  );

  g711_pipe_reg #(.W(PAY_W)) u_rx_stage (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (rx_in_valid),
    .in_ready  (rx_in_ready),
    .in_data   ({rx_mode, rx_lin}),
    .out_valid (rx_out_valid),
    .out_ready (rx_out_ready),
    .out_data  ({rx_tag, rx_out_data})
  );

  // R4: companded transmit words have a clear low byte
  a_r4_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tx_out_valid && tx_tag[1] |-> tx_out_data[LOW_W-1:0] == '0);

  // R5: mu-law expansion never leaves its reconstruction range
  a_r5_mu_bound: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_tag == CMP_MU |->
      $signed(rx_out_data) <= 32124 && $signed(rx_out_data) >= -32124);

  // R6: A-law expansion has no zero level
  a_r6_a_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    rx_out_valid && rx_tag == CMP_A |-> rx_out_data != '0);
endmodule

// File: tb/test_g711_compander.sv
module test_g711_compander;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] tx_mode = 2'b00, rx_mode = 2'b00;
  logic word8_mode;
  logic tx_in_valid = 1'b0, tx_out_ready = 1'b1;
  logic rx_in_valid = 1'b0, rx_out_ready = 1'b1;
  logic tx_in_ready, tx_out_valid, rx_in_ready, rx_out_valid;
  logic [15:0] tx_in_data = '0, rx_in_data = '0, tx_out_data, rx_out_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  g711_compander i_g711_compander (
    .clk(clk), .rst_n(rst_n), .tx_mode(tx_mode), .rx_mode(rx_mode),
    .word8_mode(word8_mode),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data),
    .rx_out_valid(rx_out_valid), .rx_out_ready(rx_out_ready), .rx_out_data(rx_out_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_mu(input logic signed [15:0] s);
    int x, b, seg;
    logic [7:0] c;
    x = s >>> 2;
    b = (x < 0) ? -x : x;
    if (b > 8159) b = 8159;
    b = b + 33;
    seg = 8;
    for (int k = 0; k < 8; k++) if (seg == 8 && b < (64 << k)) seg = k;
    if (seg == 8) c = {s[15], 3'd7, 4'hF};
    else c = {s[15], 3'(seg), 4'((b >> (seg + 1)) & 15)};
    return ~c;
  endfunction

  function automatic logic [7:0] ref_a(input logic signed [15:0] s);
    int x, m, seg, st;
    x = s >>> 3;
    m = (x < 0) ? (-x - 1) : x;
    seg = 7;
    for (int k = 7; k >= 0; k--) if (m < (32 << k)) seg = k;
    st = (seg < 2) ? ((m >> 1) & 15) : ((m >> seg) & 15);
    return {(x >= 0), 3'(seg), 4'(st)} ^ 8'h55;
  endfunction

  function automatic logic [15:0] ref_mu_dec(input logic [7:0] c);
    int u, t;
    u = (~c) & 255;
    t = (((u & 15) << 3) + 132) << ((u >> 4) & 7);
    return 16'(((u & 128) != 0) ? (132 - t) : (t - 132));
  endfunction

  function automatic logic [15:0] ref_a_dec(input logic [7:0] c);
    int a, t, seg;
    a = c ^ 85;
    t = (a & 15) << 4;
    seg = (a >> 4) & 7;
    if (seg == 0) t = t + 8;
    else t = (t + 264) << (seg - 1);
    return 16'(((a & 128) != 0) ? t : -t);
  endfunction

  // one word on each path, both accepted on the same edge, results read after it
  task automatic xfer(input logic [15:0] ts, input logic [1:0] tm,
                      input logic [15:0] rw, input logic [1:0] rm,
                      output logic [15:0] tg, output logic [15:0] rg,
                      output logic tv, output logic rv);
    @(negedge clk);
    tx_in_valid = 1'b1; tx_in_data = ts; tx_mode = tm;
    rx_in_valid = 1'b1; rx_in_data = rw; rx_mode = rm;
    @(negedge clk);
    tx_in_valid = 1'b0; rx_in_valid = 1'b0;
    tg = tx_out_data; rg = rx_out_data; tv = tx_out_valid; rv = rx_out_valid;
  endtask

  task automatic t_reset;
    chk("R8 reset tx_out_valid", 32'(tx_out_valid), 32'd0);
    chk("R8 reset rx_out_valid", 32'(rx_out_valid), 32'd0);
    chk("R8 reset tx_in_ready", 32'(tx_in_ready), 32'd1);
    chk("R8 reset rx_in_ready", 32'(rx_in_ready), 32'd1);
  endtask

  task automatic t_bypass;
    logic [15:0] tg, rg;
    logic tv, rv;
    xfer(16'h8123, 2'b00, 16'h5A3C, 2'b00, tg, rg, tv, rv);
    chk("R1 off tx pass", 32'(tg), 32'h8123);
    chk("R1 off rx pass", 32'(rg), 32'h5A3C);
    chk("R8 tx latency valid", 32'(tv), 32'd1);
    chk("R8 rx latency valid", 32'(rv), 32'd1);
    xfer(16'h7FFE, 2'b01, 16'h0001, 2'b01, tg, rg, tv, rv);
    chk("R1 reserved tx pass", 32'(tg), 32'h7FFE);
    chk("R1 reserved rx pass", 32'(rg), 32'h0001);
  endtask

  task automatic t_mu_enc;
    logic [15:0] tg, rg;
    logic tv, rv;
    xfer(16'h0000, 2'b10, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R2 mu zero", 32'(tg), 32'hFF00);
    xfer(16'h7FFF, 2'b10, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R2 mu max", 32'(tg), 32'h8000);
    xfer(16'h8000, 2'b10, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R2 mu min", 32'(tg), 32'h0000);
    for (int i = 0; i < 700; i++) begin
      logic [15:0] s;
      s = 16'(-32768 + i * 94 + (i % 7));
      xfer(s, 2'b10, 16'h0, 2'b00, tg, rg, tv, rv);
      chk("R2 R4 mu sweep", 32'(tg), 32'({ref_mu(s), 8'h00}));
    end
  endtask

  task automatic t_a_enc;
    logic [15:0] tg, rg;
    logic tv, rv;
    xfer(16'h0000, 2'b11, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R3 A zero", 32'(tg), 32'hD500);
    xfer(16'h7FFF, 2'b11, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R3 A max", 32'(tg), 32'hAA00);
    xfer(16'h8000, 2'b11, 16'h0, 2'b00, tg, rg, tv, rv);
    chk("R3 A min", 32'(tg), 32'h2A00);
    for (int i = 0; i < 700; i++) begin
      logic [15:0] s;
      s = 16'(32767 - i * 93 - (i % 5));
      xfer(s, 2'b11, 16'h0, 2'b00, tg, rg, tv, rv);
      chk("R3 R4 A sweep", 32'(tg), 32'({ref_a(s), 8'h00}));
    end
  endtask

  task automatic t_decode;
    logic [15:0] tg, rg;
    logic tv, rv;
    xfer(16'h0, 2'b00, 16'hFF00, 2'b10, tg, rg, tv, rv);
    chk("R5 mu decode FF", 32'(rg), 32'h0000);
    xfer(16'h0, 2'b00, 16'h8077, 2'b10, tg, rg, tv, rv);
    chk("R5 mu decode 80", 32'(rg), 32'(16'd32124));
    xfer(16'h0, 2'b00, 16'hD5E1, 2'b11, tg, rg, tv, rv);
    chk("R6 A decode D5", 32'(rg), 32'h0008);
    xfer(16'h0, 2'b00, 16'hAA00, 2'b11, tg, rg, tv, rv);
    chk("R6 A decode AA", 32'(rg), 32'(16'd32256));
    for (int c = 0; c < 256; c++) begin
      logic [7:0] junk;
      junk = 8'(c * 37 + 11);
      xfer(16'h0, 2'b00, {8'(c), junk}, 2'b10, tg, rg, tv, rv);
      chk("R5 mu decode all", 32'(rg), 32'(ref_mu_dec(8'(c))));
      xfer(16'h0, 2'b00, {8'(c), ~junk}, 2'b11, tg, rg, tv, rv);
      chk("R6 A decode all", 32'(rg), 32'(ref_a_dec(8'(c))));
    end
  endtask

  task automatic t_word8;
    logic [1:0] tm, rm;
    for (int i = 0; i < 16; i++) begin
      tm = 2'(i); rm = 2'(i >> 2);
      @(negedge clk);
      tx_mode = tm; rx_mode = rm;
      #1;
      chk("R7 word8 flag", 32'(word8_mode), 32'(tm[1] | rm[1]));
    end
  endtask

  task automatic t_concurrent;
    logic [15:0] tg, rg;
    logic tv, rv;
    xfer(16'h1234, 2'b10, 16'h2A00, 2'b11, tg, rg, tv, rv);
    chk("R10 same-cycle tx mu", 32'(tg), 32'({ref_mu(16'h1234), 8'h00}));
    chk("R10 same-cycle rx A", 32'(rg), 32'(ref_a_dec(8'h2A)));
    xfer(16'hC001, 2'b11, 16'h1700, 2'b10, tg, rg, tv, rv);
    chk("R10 same-cycle tx A", 32'(tg), 32'({ref_a(16'hC001), 8'h00}));
    chk("R10 same-cycle rx mu", 32'(rg), 32'(ref_mu_dec(8'h17)));
    // stall only tx; rx keeps streaming
    @(negedge clk);
    tx_out_ready = 1'b0;
    tx_in_valid = 1'b1; tx_in_data = 16'h0400; tx_mode = 2'b10;
    @(negedge clk);
    tx_in_data = 16'hFC00; tx_mode = 2'b11;
    chk("R9 ready low while stalled", 32'(tx_in_ready), 32'd0);
    for (int k = 0; k < 4; k++) begin
      rx_in_valid = 1'b1; rx_in_data = {8'(k * 29), 8'h00}; rx_mode = 2'b10;
      @(negedge clk);
      chk("R10 rx flows during tx stall", 32'({rx_out_valid, rx_out_data}),
          32'({1'b1, ref_mu_dec(8'(k * 29))}));
      chk("R9 tx held", 32'(tx_out_data), 32'({ref_mu(16'h0400), 8'h00}));
      chk("R9 tx held valid", 32'(tx_out_valid), 32'd1);
    end
    rx_in_valid = 1'b0;
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_in_valid = 1'b0;
    chk("R9 second word after release", 32'(tx_out_data), 32'({ref_a(16'hFC00), 8'h00}));
    @(negedge clk);
    chk("R9 no duplicate", 32'(tx_out_valid), 32'd0);
  endtask

  task automatic t_mode_capture;
    @(negedge clk);
    rx_out_ready = 1'b0;
    rx_in_valid = 1'b1; rx_in_data = 16'h9C00; rx_mode = 2'b11;
    @(negedge clk);
    rx_in_valid = 1'b0; rx_mode = 2'b10;
    chk("R11 captured value", 32'(rx_out_data), 32'(ref_a_dec(8'h9C)));
    @(negedge clk);
    rx_mode = 2'b00;
    @(negedge clk);
    chk("R11 mode change ignored", 32'(rx_out_data), 32'(ref_a_dec(8'h9C)));
    rx_out_ready = 1'b1;
    @(negedge clk);
    chk("R9 taken once", 32'(rx_out_valid), 32'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R8 watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bypass();
    t_mu_enc();
    t_a_enc();
    t_decode();
    t_word8();
    t_concurrent();
    t_mode_capture();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule